// File: doc/BRIEF.md
# Converter Power Mode Sequencer

This block decides which power state a data converter core runs in: full operation (Normal), a light power-saving state that keeps the serial link alive (Nap), or a deep power-saving state that shuts the link down (Sleep). After reset it always waits for the core's power-up calibration to finish, whatever mode is being asked for. Only then does it follow the requested mode.

The requested mode comes from one of two places. A decoded mode pin is the default source. An override register, written over a simple write strobe, takes its place when the register is enabled. The override register stays locked until the pin has asked for Normal at least once since reset. In Nap the block keeps the lanes enabled and repeats the last sample it captured in Normal. In Sleep it drops the lane enable. When it leaves Sleep it issues a one-cycle realignment request, and it marks the link usable only after that request.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cal_busy` is 1. On those cycles `lane_en`, `out_valid`, `realign_req`, `link_ready` and `ovr_unlocked` are all 0 and `cur_mode` is 00.
- R2: `cal_busy` stays 1, with `lane_en` at 0 and `cur_mode` at Normal, until a cycle in which `cal_done` is 1. It falls on the following cycle and never rises again before the next reset.
- R3: Mode codes are 00 Normal, 01 Nap and 10 Sleep. A pin code of 11 counts as Normal. With no override enabled, `cur_mode` equals the decoded pin code one cycle after it is presented, once calibration is over.
- R4: An enabled override mode takes precedence over the pin. `cur_mode` follows the override one cycle after the override register takes the value.
- R5: A write (`cfg_we`=1) made while `ovr_unlocked` is 0 has no effect on the override register or on `cur_mode`.
- R6: `ovr_unlocked` becomes 1 on the cycle after the first cycle in which the pin decodes to Normal. It then stays 1 until reset.
- R7: An accepted write with `cfg_en`=0 disables the override, so the pin again sets the mode.
- R8: An accepted write with `cfg_en`=1 and `cfg_mode`=11 is ignored. The previous override setting stays in force.
- R9: In Nap, `lane_en` and `out_valid` are 1 on every cycle. `out_data` repeats the last sample captured in Normal, and new input samples are ignored.
- R10: In Sleep, `lane_en` and `out_valid` are 0.
- R11: `realign_req` is a single-cycle pulse. It is high exactly on the first cycle in which `cur_mode` leaves Sleep, whether the new mode is Normal or Nap.
- R12: `link_ready` is 1 exactly when `lane_en` is 1 and `realign_req` is 0.
- R13: In Normal, a sample presented with `smp_valid`=1 appears on `out_data` with `out_valid`=1 one cycle later. A cycle without a valid sample gives `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_mode | input | 2 | Decoded mode pin code |
| cfg_we | input | 1 | Override register write strobe |
| cfg_en | input | 1 | Override enable bit for the write |
| cfg_mode | input | 2 | Override mode code for the write |
| cal_done | input | 1 | Power-up calibration finished |
| smp_valid | input | 1 | Input sample valid |
| smp_data | input | DATA_W | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_data | output | DATA_W | Output sample (held in Nap) |
| lane_en | output | 1 | Serial lanes enabled |
| realign_req | output | 1 | Code-group realignment request pulse |
| link_ready | output | 1 | Link usable |
| cur_mode | output | 2 | Effective power mode |
| ovr_unlocked | output | 1 | Override register accepts writes |
| cal_busy | output | 1 | Power-up calibration in progress |

## Verification
The bench builds the block with the default 14-bit sample width. Sample values therefore span a range wide enough that a value held in Nap can be told apart from the ignored samples that arrive meanwhile. The pin requests Nap and then Sleep during calibration and right after it. This makes the lockout and the calibration priority observable before the override ever unlocks. Later, override writes that set a mode, write an illegal code and clear the enable run against a pin at Normal, so that each outcome shows up in `cur_mode`.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_NAP    = 2'b01,
    PM_SLEEP  = 2'b10
  } pm_t;

  // Pin decode: the unused code falls back to full operation.
  function automatic pm_t pm_decode(input logic [1:0] code);
    case (code)
      2'b01:   return PM_NAP;
      2'b10:   return PM_SLEEP;
      default: return PM_NORMAL;
    endcase
  endfunction

  function automatic logic pm_code_ok(input logic [1:0] code);
    return code != 2'b11;
  endfunction

  // Mode request: an enabled override outranks the pin.
  function automatic pm_t pm_select(input logic ovr_on, input pm_t ovr, input logic [1:0] pin);
    return ovr_on ? ovr : pm_decode(pin);
  endfunction

endpackage

// File: rtl/pms_calib_gate.sv
module pms_calib_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_done,
  output logic cal_busy
);

  logic cal_finish;
  assign cal_finish = cal_busy & cal_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cal_busy <= 1'b1;
    else if (cal_finish) cal_busy <= 1'b0;
  end

  assert_cal_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> $past(cal_done));

  assert_cal_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_busy |=> !cal_busy);

endmodule

// File: rtl/pms_override.sv
module pms_override
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_is_normal,
  input  logic       cfg_we,
  input  logic       cfg_en,
  input  logic [1:0] cfg_mode,
  output logic       unlocked,
  output logic       ovr_en,
  output pm_t        ovr_mode
);

  logic wr_accept, wr_clear, wr_set;
  assign wr_accept = cfg_we & unlocked;
  assign wr_clear  = wr_accept & ~cfg_en;
  assign wr_set    = wr_accept & cfg_en & pm_code_ok(cfg_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlocked <= 1'b0;
    else        unlocked <= unlocked | pin_is_normal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_en   <= 1'b0;
      ovr_mode <= PM_NORMAL;
    end else if (wr_clear) begin
      ovr_en   <= 1'b0;
    end else if (wr_set) begin
      ovr_en   <= 1'b1;
      ovr_mode <= pm_t'(cfg_mode);
    end
  end

  assert_locked_no_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> !ovr_en);

  assert_unlock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  assert_bad_code_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_en && cfg_mode == 2'b11) |=> ($stable(ovr_en) && $stable(ovr_mode)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && unlocked && !cfg_en) |=> !ovr_en);

endmodule

// File: rtl/pms_mode_ctrl.sv
module pms_mode_ctrl
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_busy,
  input  logic [1:0] pin_mode,
  input  logic       ovr_en,
  input  pm_t        ovr_mode,
  output pm_t        cur,
  output logic       realign,
  output logic       lane_en,
  output logic       link_ready
);

  pm_t  mode_req, mode_nxt;
  logic wake_evt;

  assign mode_req = pm_select(ovr_en, ovr_mode, pin_mode);
  assign mode_nxt = cal_busy ? PM_NORMAL : mode_req;
  assign wake_evt = (cur == PM_SLEEP) && (mode_nxt != PM_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= PM_NORMAL;
      realign <= 1'b0;
    end else begin
      cur     <= mode_nxt;
      realign <= wake_evt;
    end
  end

  assign lane_en    = ~cal_busy & (cur != PM_SLEEP);
  assign link_ready = lane_en & ~realign;

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !realign);

  assert_pulse_after_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> ($past(cur) == PM_SLEEP && cur != PM_SLEEP));

  assert_wake_has_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur) == PM_SLEEP && cur != PM_SLEEP) |-> realign);

  assert_wake_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur) == PM_SLEEP && cur != PM_SLEEP) |-> !link_ready);

  assert_cal_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |=> (cur == PM_NORMAL));

endmodule

// File: rtl/pms_sample_hold.sv
module pms_sample_hold
  import pms_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  pm_t               cur,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic in_normal, in_nap, in_sleep, capture;
  assign in_normal = run & (cur == PM_NORMAL);
  assign in_nap    = run & (cur == PM_NAP);
  assign in_sleep  = run & (cur == PM_SLEEP);
  assign capture   = in_normal & smp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= capture | in_nap;
      if (capture) out_data <= smp_data;
    end
  end

  assert_nap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_nap |=> ($stable(out_data) && out_valid));

  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep |=> !out_valid);

  assert_pass_R13: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (out_valid && out_data == $past(smp_data)));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pin_mode,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_mode,
  input  logic              cal_done,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              lane_en,
  output logic              realign_req,
  output logic              link_ready,
  output logic [1:0]        cur_mode,
  output logic              ovr_unlocked,
  output logic              cal_busy
);

  logic pin_is_normal, ovr_en;
  pm_t  ovr_mode, cur;

  assign pin_is_normal = (pm_decode(pin_mode) == PM_NORMAL);

  pms_calib_gate u_cal (
    .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .cal_busy(cal_busy)
  );

  pms_override u_ovr (
    .clk(clk), .rst_n(rst_n), .pin_is_normal(pin_is_normal),
    .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .unlocked(ovr_unlocked), .ovr_en(ovr_en), .ovr_mode(ovr_mode)
  );

  pms_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .cal_busy(cal_busy), .pin_mode(pin_mode),
    .ovr_en(ovr_en), .ovr_mode(ovr_mode), .cur(cur), .realign(realign_req),
    .lane_en(lane_en), .link_ready(link_ready)
  );

  pms_sample_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .run(~cal_busy), .cur(cur),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  assign cur_mode = cur;

  assert_sleep_lanes_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b10) |-> !link_ready);

  assert_ovr_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && ovr_en) |=> (cur_mode == $past(ovr_mode)));

endmodule

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
  localparam int DW = 14;

  logic clk = 0, rst_n = 0;
  logic [1:0] pin_mode = 2'b01, cfg_mode = 0;
  logic cfg_we = 0, cfg_en = 0, cal_done = 0, smp_valid = 0;
  logic [DW-1:0] smp_data = 0;
  logic out_valid, lane_en, realign_req, link_ready, ovr_unlocked, cal_busy;
  logic [DW-1:0] out_data;
  logic [1:0] cur_mode;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  pwr_mode_seq #(.DATA_W(DW)) u_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_mode(cfg_mode), .cal_done(cal_done), .smp_valid(smp_valid), .smp_data(smp_data),
    .out_valid(out_valid), .out_data(out_data), .lane_en(lane_en), .realign_req(realign_req),
    .link_ready(link_ready), .cur_mode(cur_mode), .ovr_unlocked(ovr_unlocked), .cal_busy(cal_busy)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference state
  int m_cal = 1, m_unl = 0, m_oen = 0, m_omode = 0, m_cur = 0, m_rq = 0, m_vld = 0, m_dat = 0;

  function automatic int dec(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b10) return 2;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cal = 1; m_unl = 0; m_oen = 0; m_omode = 0; m_cur = 0; m_rq = 0; m_vld = 0; m_dat = 0;
    end else begin
      int want, nxt;
      want = m_oen ? m_omode : dec(pin_mode);
      nxt = m_cal ? 0 : want;
      if (!m_cal && m_cur == 0 && smp_valid) begin m_vld = 1; m_dat = int'(smp_data); end
      else m_vld = (!m_cal && m_cur == 1) ? 1 : 0;
      if (cfg_we && m_unl) begin
        if (!cfg_en) m_oen = 0;
        else if (cfg_mode != 2'b11) begin m_oen = 1; m_omode = int'(cfg_mode); end
      end
      if (dec(pin_mode) == 0) m_unl = 1;
      m_rq = (m_cur == 2 && nxt != 2) ? 1 : 0;
      if (m_cal && cal_done) m_cal = 0;
      m_cur = nxt;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    int lane;
    cyc++;
    if (!done) begin
      lane = (!m_cal && m_cur != 2) ? 1 : 0;
      check("R2 cal_busy", int'(cal_busy), m_cal);
      check("R3 cur_mode", int'(cur_mode), m_cur);
      check("R6 ovr_unlocked", int'(ovr_unlocked), m_unl);
      check("R10 lane_en", int'(lane_en), lane);
      check("R11 realign_req", int'(realign_req), m_rq);
      check("R12 link_ready", int'(link_ready), (lane && !m_rq) ? 1 : 0);
      check("R13 out_valid", int'(out_valid), m_vld);
      check("R9 out_data", int'(out_data), m_dat);
    end
    if (cyc > 5000 && !done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic en, input logic [1:0] md);
    cfg_we = 1; cfg_en = en; cfg_mode = md;
    waitn(1);
    cfg_we = 0;
  endtask

  initial begin
    waitn(2);
    check("R1 cal_busy in reset", int'(cal_busy), 1);
    check("R1 lane_en in reset", int'(lane_en), 0);
    check("R1 unlocked in reset", int'(ovr_unlocked), 0);
    rst_n = 1;
    waitn(1);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 cur_mode after reset", int'(cur_mode), 0);
    pin_mode = 2'b10;
    waitn(6);
    check("R2 calibration still busy", int'(cal_busy), 1);
    check("R2 lanes off in calibration", int'(lane_en), 0);
    cal_done = 1; waitn(1); cal_done = 0;
    waitn(3);
    check("R3 pin sleep followed", int'(cur_mode), 2);
    check("R10 sleep lanes off", int'(lane_en), 0);
    wr(1, 2'b00);
    waitn(3);
    check("R5 locked write ignored", int'(cur_mode), 2);
    check("R5 still locked", int'(ovr_unlocked), 0);
    pin_mode = 2'b01;
    waitn(3);
    check("R3 pin nap followed", int'(cur_mode), 1);
    check("R12 link ready after wake", int'(link_ready), 1);
    pin_mode = 2'b00;
    waitn(2);
    for (int i = 0; i < 10; i++) begin
      smp_valid = 1; smp_data = DW'(100 + i * 37);
      waitn(1);
    end
    smp_valid = 0;
    waitn(1);
    check("R6 unlocked after normal", int'(ovr_unlocked), 1);
    check("R13 last sample out", int'(out_data), 433);
    pin_mode = 2'b01;
    waitn(2);
    smp_valid = 1; smp_data = DW'(999);
    waitn(4);
    check("R9 nap holds sample", int'(out_data), 433);
    check("R9 nap valid", int'(out_valid), 1);
    smp_valid = 0;
    pin_mode = 2'b00;
    waitn(3);
    wr(1, 2'b10);
    waitn(3);
    check("R4 override sleep wins", int'(cur_mode), 2);
    wr(1, 2'b11);
    waitn(3);
    check("R8 bad code ignored", int'(cur_mode), 2);
    wr(0, 2'b01);
    waitn(3);
    check("R7 pin back in control", int'(cur_mode), 0);
    pin_mode = 2'b01; waitn(3);
    check("R3 nap again", int'(cur_mode), 1);
    pin_mode = 2'b11; waitn(3);
    check("R3 code 11 is normal", int'(cur_mode), 0);
    wr(1, 2'b01); waitn(3);
    check("R4 override nap wins", int'(cur_mode), 1);
    wr(1, 2'b10); waitn(2);
    wr(0, 2'b00); waitn(3);
    check("R11 wake from override sleep", int'(cur_mode), 0);
    waitn(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule